// File: doc/BRIEF.md
# Mixed-precision vector register file mapper

This block holds the register configuration of a banked vector register file and turns a (register type, register number, element index) triple into a physical location. The file has eight banks of 256 entries of 64 bits. Software states how many integer, double, single and half-precision vector registers it wants, and may ask for a vector length. From these counts the block derives how many elements each bank can hold and the resulting hardware vector length. It keeps the requested length when that length is non-zero and shorter than the maximum.

Every element's registers live in one bank, bank = element index mod 8. Inside a bank the storage is split into consecutive regions in the fixed order integer, double, single, half. A register of a type sits at a constant stride from its region base. Single-precision registers pack two elements per entry and half-precision registers pack four. Elements that share an entry have indices eight apart. A query returns the bank, entry, subword lane and byte write mask, plus flags for the hardwired zero register and for an out-of-range query.

Top module: `vrf_mapper`

## Requirements
- R1: After a configuration, with k = max(int_count-1,0), the block picks the largest n ≤ 256 for which k·n + dbl·n + sgl·ceil(n/2) + hlf·ceil(n/4) ≤ 256. With no request in force, vl = 8·n.
- R2: A non-zero requested length smaller than 8·n becomes vl. A zero request, or one that is not smaller, leaves vl = 8·n.
- R3: If the integer count exceeds 32, or dbl+sgl+hlf exceeds 32, or no n ≥ 1 fits, then cfg_err is 1 and vl is 0.
- R4: q_bank equals q_elem mod 8.
- R5: Let m = ceil(vl/8) and slot = q_elem div 8. The layout then uses strides m, m, ceil(m/2) and ceil(m/4) for type codes 0 (int), 1 (double), 2 (single) and 3 (half). The bases are 0, k·m, plus dbl·m, plus sgl·ceil(m/2), in that order. q_entry is the base, plus the stride times the storage index, plus slot div density. The storage index is reg-1 for integers and reg for the others.
- R6: The density is 1, 1, 2 and 4 for type codes 0 to 3, and q_lane = slot mod density.
- R7: q_wmask is 0xFF for types 0 and 1. For type 2 it is 0x0F in lane 0 and 0xF0 in lane 1. For type 3 it is 0x03 shifted left by 2·lane.
- R8: For type 0 with register 0, q_zero is 1 and q_wmask is 0.
- R9: q_fault is 1 exactly when cfg_err is 1, or q_elem ≥ vl, or the register number is not below the configured count for its type.
- R10: The configuration is taken on a clock edge with cfg_valid high, and vl and cfg_err show it one cycle later. Changes to the configuration inputs without cfg_valid have no effect. Reset gives vl = 0 and cfg_err = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_valid | input | 1 | Load configuration |
| cfg_nint | input | 6 | Integer register count, register 0 included |
| cfg_ndbl | input | 6 | Double-precision register count |
| cfg_nsgl | input | 6 | Single-precision register count |
| cfg_nhlf | input | 6 | Half-precision register count |
| cfg_req_vl | input | 12 | Requested vector length, 0 = maximum |
| vl | output | 12 | Hardware vector length |
| cfg_err | output | 1 | Configuration rejected |
| q_type | input | 2 | Query type: 0 int, 1 double, 2 single, 3 half |
| q_reg | input | 5 | Query register number |
| q_elem | input | 12 | Query element index |
| q_bank | output | 3 | Bank holding the element |
| q_entry | output | 8 | Entry address within the bank |
| q_lane | output | 2 | Subword lane within the entry |
| q_wmask | output | 8 | Byte write mask for the element |
| q_zero | output | 1 | Query names the hardwired zero register |
| q_fault | output | 1 | Query outside the configured state |

## Verification
The assertions check on every cycle that a rejected configuration shows a zero length, and that vl moves only after a load. They also check that each valid query lands inside the bank depth, with a lane in range for its density and a mask of the right byte weight. The zero register must write nothing. Only the bench scenarios can show that the chosen length is really the largest one that fits, that a request is honoured or ignored correctly, and that the region order and strides produce the exact entry numbers. They do this by comparing against an independent linear-search model over a table of configurations.

// File: rtl/vrf_mapper.sv
`timescale 1ns/1ps
module vrf_mapper #(
  parameter int NBANK  = 8,
  parameter int DEPTH  = 256,
  parameter int MAXREG = 32,
  localparam int VLW = $clog2(NBANK*DEPTH) + 1,
  localparam int CW  = $clog2(MAXREG) + 1,
  localparam int RW  = $clog2(MAXREG),
  localparam int BW  = $clog2(NBANK),
  localparam int AW  = $clog2(DEPTH),
  localparam int NW  = AW + 1,
  localparam int UW  = NW + CW + 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_valid,
  input  logic [CW-1:0]  cfg_nint,
  input  logic [CW-1:0]  cfg_ndbl,
  input  logic [CW-1:0]  cfg_nsgl,
  input  logic [CW-1:0]  cfg_nhlf,
  input  logic [VLW-1:0] cfg_req_vl,
  output logic [VLW-1:0] vl,
  output logic           cfg_err,
  input  logic [1:0]     q_type,
  input  logic [RW-1:0]  q_reg,
  input  logic [VLW-1:0] q_elem,
  output logic [BW-1:0]  q_bank,
  output logic [AW-1:0]  q_entry,
  output logic [1:0]     q_lane,
  output logic [7:0]     q_wmask,
  output logic           q_zero,
  output logic           q_fault
);

  function automatic logic [UW-1:0] usage(input logic [NW-1:0] n,
      input logic [CW-1:0] i, input logic [CW-1:0] d,
      input logic [CW-1:0] s, input logic [CW-1:0] h);
    logic [UW-1:0] nn;
    nn = UW'(n);
    return UW'(i) * nn + UW'(d) * nn + UW'(s) * ((nn + 1) >> 1) + UW'(h) * ((nn + 3) >> 2);
  endfunction

  function automatic logic [NW-1:0] fit(input logic [CW-1:0] i, input logic [CW-1:0] d,
      input logic [CW-1:0] s, input logic [CW-1:0] h);
    logic [NW-1:0] lo, c;
    lo = '0;
    for (int b = NW - 1; b >= 0; b--) begin
      c = lo | NW'(1 << b);
      if (UW'(c) <= UW'(DEPTH) && usage(c, i, d, s, h) <= UW'(DEPTH)) lo = c;
    end
    return lo;
  endfunction

  logic [CW-1:0]  ist;
  logic [CW+1:0]  fp_sum;
  logic [NW-1:0]  nmax, n_n;
  logic [VLW-1:0] maxvl, vl_n;
  logic           bad;

  assign ist    = (cfg_nint == '0) ? '0 : cfg_nint - 1'b1;
  assign fp_sum = (CW+2)'(cfg_ndbl) + (CW+2)'(cfg_nsgl) + (CW+2)'(cfg_nhlf);
  assign nmax   = fit(ist, cfg_ndbl, cfg_nsgl, cfg_nhlf);
  assign maxvl  = VLW'(nmax) * VLW'(NBANK);
  assign bad    = (32'(cfg_nint) > MAXREG) || (32'(fp_sum) > MAXREG) || (nmax == '0);
  assign vl_n   = bad ? '0 : ((cfg_req_vl != '0 && cfg_req_vl < maxvl) ? cfg_req_vl : maxvl);
  assign n_n    = NW'((32'(vl_n) + NBANK - 1) / NBANK);

  logic [NW-1:0] n_q;
  logic [CW-1:0] ni_q, nd_q, ns_q, nh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl <= '0; cfg_err <= 1'b0; n_q <= '0;
      ni_q <= '0; nd_q <= '0; ns_q <= '0; nh_q <= '0;
    end else if (cfg_valid) begin
      vl <= vl_n; cfg_err <= bad; n_q <= n_n;
      ni_q <= cfg_nint; nd_q <= cfg_ndbl; ns_q <= cfg_nsgl; nh_q <= cfg_nhlf;
    end
  end

  logic [CW-1:0]  sint, cnt;
  logic [UW-1:0]  s2, s4, base_d, base_s, base_h, base, stride, sub, entry_full;
  logic [VLW-1:0] slot;
  logic [RW-1:0]  ridx;
  logic [7:0]     mask;

  assign sint   = (ni_q == '0) ? '0 : ni_q - 1'b1;
  assign s2     = (UW'(n_q) + 1) >> 1;
  assign s4     = (UW'(n_q) + 3) >> 2;
  assign base_d = UW'(sint) * UW'(n_q);
  assign base_s = base_d + UW'(nd_q) * UW'(n_q);
  assign base_h = base_s + UW'(ns_q) * s2;
  assign slot   = q_elem >> BW;

  always_comb begin
    ridx = q_reg; base = '0; stride = UW'(n_q); sub = UW'(slot);
    q_lane = 2'd0; mask = 8'hFF; cnt = ni_q;
    case (q_type)
      2'd0: ridx = q_reg - 1'b1;
      2'd1: begin base = base_d; cnt = nd_q; end
      2'd2: begin
        base = base_s; stride = s2; sub = UW'(slot >> 1);
        q_lane = {1'b0, slot[0]}; mask = slot[0] ? 8'hF0 : 8'h0F; cnt = ns_q;
      end
      default: begin
        base = base_h; stride = s4; sub = UW'(slot >> 2);
        q_lane = slot[1:0]; mask = 8'h03 << {slot[1:0], 1'b0}; cnt = nh_q;
      end
    endcase
  end

  assign entry_full = base + stride * UW'(ridx) + sub;
  assign q_entry    = entry_full[AW-1:0];
  assign q_bank     = q_elem[BW-1:0];
  assign q_zero     = (q_type == 2'd0) && (q_reg == '0);
  assign q_wmask    = q_zero ? 8'h00 : mask;
  assign q_fault    = cfg_err || (q_elem >= vl) || ({1'b0, q_reg} >= cnt);

endmodule

// File: rtl/vrf_mapper_chk.sv
`timescale 1ns/1ps
module vrf_mapper_chk #(
  parameter int VLW = 12,
  parameter int UW = 18,
  parameter int DEPTH = 256
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_valid,
  input logic [VLW-1:0] vl,
  input logic           cfg_err,
  input logic [1:0]     q_type,
  input logic           q_zero,
  input logic           q_fault,
  input logic [1:0]     q_lane,
  input logic [7:0]     q_wmask,
  input logic [UW-1:0]  entry_full
);

  a_r3_err_zero_vl: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> vl == '0);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |=> $stable(vl) && $stable(cfg_err));

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_fault && !q_zero) |-> entry_full < UW'(DEPTH));

  a_r6_lane_range: assert property (@(posedge clk) disable iff (!rst_n)
    (q_type < 2'd2 |-> q_lane == 2'd0) and (q_type == 2'd2 |-> q_lane < 2'd2));

  a_r7_mask_weight: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_fault && !q_zero) |-> $countones(q_wmask) == ((q_type < 2'd2) ? 8 : (q_type == 2'd2) ? 4 : 2));

  a_r8_zero_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
    q_zero |-> q_wmask == 8'h00);

endmodule

bind vrf_mapper vrf_mapper_chk #(.VLW(VLW), .UW(UW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .vl(vl), .cfg_err(cfg_err),
  .q_type(q_type), .q_zero(q_zero), .q_fault(q_fault), .q_lane(q_lane),
  .q_wmask(q_wmask), .entry_full(entry_full)
);

// File: tb/vrf_mapper_tb.sv
`timescale 1ns/1ps
module vrf_mapper_tb;
  logic clk = 0, rst_n = 0, cfg_valid = 0;
  logic [5:0] cfg_nint = 0, cfg_ndbl = 0, cfg_nsgl = 0, cfg_nhlf = 0;
  logic [11:0] cfg_req_vl = 0, vl, q_elem = 0;
  logic cfg_err, q_zero, q_fault;
  logic [1:0] q_type = 0, q_lane;
  logic [4:0] q_reg = 0;
  logic [2:0] q_bank;
  logic [7:0] q_entry, q_wmask;
  int nchk = 0, nerr = 0;
  int g_ni, g_nd, g_ns, g_nh, g_vl, g_err;

  always #2 clk = ~clk;

  vrf_mapper u_dut (.*);

  localparam int NT = 10;
  localparam logic [48:0] TAB [NT] = '{
    {6'd2, 6'd1, 6'd1, 6'd2, 12'd0, 12'd672, 1'b0},
    {6'd0, 6'd0, 6'd0, 6'd0, 12'd0, 12'd2048, 1'b0},
    {6'd32, 6'd0, 6'd0, 6'd0, 12'd0, 12'd64, 1'b0},
    {6'd0, 6'd0, 6'd0, 6'd32, 12'd0, 12'd256, 1'b0},
    {6'd2, 6'd1, 6'd1, 6'd2, 12'd100, 12'd100, 1'b0},
    {6'd0, 6'd0, 6'd0, 6'd0, 12'd3000, 12'd2048, 1'b0},
    {6'd33, 6'd0, 6'd0, 6'd0, 12'd0, 12'd0, 1'b1},
    {6'd1, 6'd20, 6'd13, 6'd0, 12'd0, 12'd0, 1'b1},
    {6'd1, 6'd0, 6'd32, 6'd0, 12'd0, 12'd128, 1'b0},
    {6'd5, 6'd10, 6'd10, 6'd7, 12'd0, 12'd96, 1'b0}
  };

  task automatic ck(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_vl(input int ni, nd, ns, nh, req);
    int si, mx;
    if (ni > 32 || nd + ns + nh > 32) return 0;
    si = (ni == 0) ? 0 : ni - 1;
    for (int n = 256; n >= 1; n--)
      if (si*n + nd*n + ns*((n+1)/2) + nh*((n+3)/4) <= 256) begin
        mx = 8 * n;
        return (req != 0 && req < mx) ? req : mx;
      end
    return 0;
  endfunction

  task automatic apply(input int ni, nd, ns, nh, req);
    @(negedge clk);
    cfg_nint = 6'(ni); cfg_ndbl = 6'(nd); cfg_nsgl = 6'(ns); cfg_nhlf = 6'(nh);
    cfg_req_vl = 12'(req); cfg_valid = 1;
    @(negedge clk);
    cfg_valid = 0;
    g_ni = ni; g_nd = nd; g_ns = ns; g_nh = nh;
    g_vl = ref_vl(ni, nd, ns, nh, req);
    g_err = (ni > 32 || nd + ns + nh > 32 || g_vl == 0) ? 1 : 0;
    #1;
  endtask

  task automatic query(input int t, r, e);
    int m, si, base, stride, den, slot, cnt, idx, ex_lane, ex_mask, ex_fault, ex_zero;
    q_type = 2'(t); q_reg = 5'(r); q_elem = 12'(e);
    #0.2;
    m = (g_vl + 7) / 8; si = (g_ni == 0) ? 0 : g_ni - 1; slot = e / 8;
    case (t)
      0: begin base = 0; stride = m; den = 1; cnt = g_ni; end
      1: begin base = si*m; stride = m; den = 1; cnt = g_nd; end
      2: begin base = si*m + g_nd*m; stride = (m+1)/2; den = 2; cnt = g_ns; end
      default: begin base = si*m + g_nd*m + g_ns*((m+1)/2); stride = (m+3)/4; den = 4; cnt = g_nh; end
    endcase
    idx = (t == 0) ? r - 1 : r;
    ex_lane = slot % den;
    ex_mask = (den == 1) ? 8'hFF : (den == 2) ? (8'h0F << (4*ex_lane)) : (8'h03 << (2*ex_lane));
    ex_zero = (t == 0 && r == 0) ? 1 : 0;
    ex_fault = (g_err != 0 || e >= g_vl || r >= cnt) ? 1 : 0;
    ck("R9 fault", int'(q_fault), ex_fault);
    ck("R8 zero", int'(q_zero), ex_zero);
    if (ex_zero != 0) ck("R8 zero mask", int'(q_wmask), 0);
    else if (ex_fault == 0) begin
      ck("R4 bank", int'(q_bank), e % 8);
      ck("R5 entry", int'(q_entry), base + stride*idx + slot/den);
      ck("R6 lane", int'(q_lane), ex_lane);
      ck("R7 mask", int'(q_wmask), ex_mask);
    end
  endtask

  initial begin
    #(4 * 200000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #9 rst_n = 1;
    @(negedge clk); #1;
    ck("R10 reset vl", int'(vl), 0);
    ck("R10 reset err", int'(cfg_err), 0);
    g_vl = 0; g_err = 0; g_ni = 0; g_nd = 0; g_ns = 0; g_nh = 0;
    query(1, 0, 0);

    for (int k = 0; k < NT; k++) begin
      apply(int'(TAB[k][48:43]), int'(TAB[k][42:37]), int'(TAB[k][36:31]),
            int'(TAB[k][30:25]), int'(TAB[k][24:13]));
      ck((k == 4 || k == 5) ? "R2 vl table" : "R1 vl table", int'(vl), int'(TAB[k][12:1]));
      ck("R1 vl model", int'(vl), g_vl);
      ck("R3 err", int'(cfg_err), int'(TAB[k][0]));
      for (int t = 0; t < 4; t++)
        for (int r = 0; r < 33; r += 16)
          for (int e = 0; e <= 2048; e += 157) query(t, (r > 31) ? 31 : r, e);
      query(3, 0, g_vl);
      if (g_vl > 0) query(2, 0, g_vl - 1);
    end

    apply(2, 1, 1, 2, 0);
    query(3, 1, 77);
    ck("R5 half entry", int'(q_entry), 233);
    ck("R7 half mask", int'(q_wmask), 8'h0C);
    ck("R4 half bank", int'(q_bank), 5);
    query(2, 0, 15);
    ck("R5 single entry", int'(q_entry), 168);
    ck("R7 single mask", int'(q_wmask), 8'hF0);
    query(0, 1, 3);
    ck("R5 int entry", int'(q_entry), 0);
    query(0, 2, 0);
    ck("R9 int beyond count", int'(q_fault), 1);
    query(1, 0, 672);
    ck("R9 elem at vl", int'(q_fault), 1);

    @(negedge clk);
    cfg_nint = 6'd33; cfg_req_vl = 12'd8;
    repeat (3) @(negedge clk);
    #1;
    ck("R10 no load vl", int'(vl), 672);
    ck("R10 no load err", int'(cfg_err), 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule